// File: doc/BRIEF.md
# RC Throttle Endpoint Calibration Learner

This block teaches a motor controller the throttle range of the radio transmitter it is paired with. It watches a stream of measured receiver pulse widths, given as timer-tick counts, each marked by a one-cycle valid strobe. If the first pulse after reset is long enough and calibration is allowed, the block enters learning. Otherwise it signals a skip and leaves the controller to normal operation.

During learning it captures the full-throttle endpoint, then the stop endpoint, and then a neutral endpoint when reverse operation is selected. Each endpoint is the average of a run of consecutive pulses. A run is abandoned and restarted whenever a pulse wanders too far from the pulse that opened it. After each endpoint the block asks for a number of audible beeps. The settle wait, the gap between beeps and the beep itself are timed outside the block, each through a request line that stays high until its acknowledge arrives. When the last endpoint is stored, a one-cycle done strobe is raised and the endpoint outputs hold their values.

Top module: `rc_cal_learner`

## Requirements
- R1: After reset, `learning`, `done`, `skip`, all three request outputs and all three endpoint outputs are 0.
- R2: When learning has not yet started, the first valid pulse starts learning only if `cal_allow` is 1 and the pulse is at least `PROG_THR`. In every other case `skip` pulses once, `learning` stays 0, and later pulses change nothing until reset.
- R3: The pulse that opens a run is the reference and is not summed. For the full endpoint the next 31 pulses are added into a 24-bit sum S. The endpoint value is bits 20 down to 5 of S, which is the top 16 bits of S shifted left by 3.
- R4: The stop endpoint sums 34 pulses and the neutral endpoint sums 32 pulses. Both use the same reference rule and the same value rule as R3.
- R5: A run pulse is out of range when its difference from the reference lies outside -`DRIFT` to +`DRIFT`; both limits are inclusive and within range. An out-of-range pulse abandons the run and raises `settle_req`, which stays high until `settle_ack`. The next pulse after that becomes the new reference.
- R6: In the full phase, a new reference below `PROG_THR` ends learning: `skip` pulses, `learning` falls, and no endpoint is stored.
- R7: A stop reference must be strictly below the learned full value, and a neutral reference must be at least the learned stop value. A pulse that fails this rule is passed over, and the block waits for the next pulse.
- R8: After the k-th endpoint (full = 1, stop = 2, neutral = 3), `beep_req` is raised k times, each held until `beep_ack`. Between two successive beeps `gap_req` is raised and held until `gap_ack`. No gap follows the last beep.
- R9: The neutral endpoint is learned only when `rev_mode` was 1 at learning entry; otherwise `mid_ep` stays 0. `done` pulses for one cycle after the final beep is acknowledged, and `learning` falls in the same cycle.
- R10: Pulses that arrive while a settle, beep or gap request is pending are ignored.
- R11: Once learning has ended, the endpoint outputs do not change until reset, whatever pulses arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_valid | input | 1 | One-cycle strobe marking a new measured pulse |
| pulse_len | input | W | Measured pulse width in ticks |
| cal_allow | input | 1 | Calibration permitted |
| rev_mode | input | 1 | Reverse operation: also learn neutral |
| settle_req | output | 1 | Request a settle wait after drift |
| settle_ack | input | 1 | Settle wait finished |
| beep_req | output | 1 | Request one beep |
| beep_ack | input | 1 | Beep finished |
| gap_req | output | 1 | Request an inter-beep pause |
| gap_ack | input | 1 | Pause finished |
| learning | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle strobe: all endpoints stored |
| skip | output | 1 | One-cycle strobe: calibration not performed or abandoned |
| hi_ep | output | W | Learned full-throttle width |
| lo_ep | output | W | Learned stop width |
| mid_ep | output | W | Learned neutral width |

## Verification
The hardest situations to reach are the ones that return the block to an earlier step: a drift rejection late in a run, a reference that breaks the ordering against an endpoint that was just learned, and a full-phase restart whose new reference falls below the programming threshold. The stimulus builds each of these on purpose. It completes or partly fills a run with random in-window jitter, including samples exactly at the drift limits, and then injects the offending pulse. Pulses are also sent while a handshake is pending, so that the ignore rule is shown only through correct final endpoint values.

// File: rtl/rc_cal_learner.sv
module rc_cal_learner #(
  parameter int W        = 16,
  parameter int ACC_W    = 24,
  parameter int SHIFT    = 3,
  parameter int PROG_THR = 3000,
  parameter int DRIFT    = 200,
  parameter int N_HI     = 31,
  parameter int N_LO     = 34,
  parameter int N_MID    = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pulse_valid,
  input  logic [W-1:0] pulse_len,
  input  logic         cal_allow,
  input  logic         rev_mode,
  output logic         settle_req,
  input  logic         settle_ack,
  output logic         beep_req,
  input  logic         beep_ack,
  output logic         gap_req,
  input  logic         gap_ack,
  output logic         learning,
  output logic         done,
  output logic         skip,
  output logic [W-1:0] hi_ep,
  output logic [W-1:0] lo_ep,
  output logic [W-1:0] mid_ep
);
  localparam int NMAX = (N_HI > N_LO) ? ((N_HI > N_MID) ? N_HI : N_MID)
                                      : ((N_LO > N_MID) ? N_LO : N_MID);
  localparam int CW  = $clog2(NMAX + 1);
  localparam int TOP = ACC_W - 1 - SHIFT;
  localparam logic [W-1:0] THR  = W'(PROG_THR);
  localparam logic [W-1:0] LIM  = W'(DRIFT);
  localparam logic [W-1:0] LIM2 = W'(2 * DRIFT);

  typedef enum logic [2:0] {S_IDLE, S_START, S_RUN, S_SETTLE, S_BEEP, S_GAP, S_OPER} st_t;
  localparam logic [1:0] PH_HI = 2'd0, PH_LO = 2'd1, PH_MID = 2'd2;

  st_t             st;
  logic [1:0]      ph, beeps;
  logic            rev_q;
  logic [W-1:0]    ref_q;
  logic [ACC_W-1:0] acc;
  logic [CW-1:0]   cnt;

  wire [W-1:0]     win      = pulse_len - ref_q + LIM;
  wire             drift    = win > LIM2;
  wire [ACC_W-1:0] acc_nx   = acc + ACC_W'(pulse_len);
  wire [W-1:0]     avg      = acc_nx[TOP -: W];
  wire [CW-1:0]    run_len  = (ph == PH_HI) ? CW'(N_HI) : (ph == PH_LO) ? CW'(N_LO) : CW'(N_MID);
  wire             start_ok = (ph == PH_HI) ? (pulse_len >= THR) :
                              (ph == PH_LO) ? (pulse_len < hi_ep) : (pulse_len >= lo_ep);

  assign settle_req = (st == S_SETTLE);
  assign beep_req   = (st == S_BEEP);
  assign gap_req    = (st == S_GAP);
  assign learning   = (st != S_IDLE) && (st != S_OPER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_HI; beeps <= '0; rev_q <= 1'b0;
      ref_q <= '0; acc <= '0; cnt <= '0;
      hi_ep <= '0; lo_ep <= '0; mid_ep <= '0;
      done <= 1'b0; skip <= 1'b0;
    end else begin
      done <= 1'b0;
      skip <= 1'b0;
      case (st)
        S_IDLE: if (pulse_valid) begin
          if (cal_allow && pulse_len >= THR) begin
            ref_q <= pulse_len; ph <= PH_HI; rev_q <= rev_mode;
            acc <= '0; cnt <= CW'(N_HI); st <= S_RUN;
          end else begin
            skip <= 1'b1; st <= S_OPER;
          end
        end
        S_START: if (pulse_valid) begin
          if (start_ok) begin
            ref_q <= pulse_len; acc <= '0; cnt <= run_len; st <= S_RUN;
          end else if (ph == PH_HI) begin
            skip <= 1'b1; st <= S_OPER;
          end
        end
        S_RUN: if (pulse_valid) begin
          acc <= acc_nx;
          if (drift) st <= S_SETTLE;
          else if (cnt == CW'(1)) begin
            case (ph)
              PH_HI:   hi_ep  <= avg;
              PH_LO:   lo_ep  <= avg;
              default: mid_ep <= avg;
            endcase
            beeps <= ph + 2'd1;
            st <= S_BEEP;
          end else cnt <= cnt - CW'(1);
        end
        S_SETTLE: if (settle_ack) st <= S_START;
        S_BEEP: if (beep_ack) begin
          if (beeps == 2'd1) begin
            if (ph == PH_HI) begin ph <= PH_LO; st <= S_START; end
            else if (ph == PH_LO && rev_q) begin ph <= PH_MID; st <= S_START; end
            else begin done <= 1'b1; st <= S_OPER; end
          end else begin
            beeps <= beeps - 2'd1; st <= S_GAP;
          end
        end
        S_GAP: if (gap_ack) st <= S_BEEP;
        default: st <= S_OPER;
      endcase
    end
  end

  p_settle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    settle_req && !settle_ack |=> settle_req);
  p_settle_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settle_req) |-> $past(pulse_valid));
  p_beep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beep_req && !beep_ack |=> beep_req);
  p_gap_after_beep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gap_req) |-> $past(beep_ack));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !learning && !beep_req && !done);
  p_ep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !learning |=> $stable(hi_ep) && $stable(lo_ep) && $stable(mid_ep));
endmodule

// File: tb/test_rc_cal_learner.sv
module test_rc_cal_learner;
  localparam int CLK_NS = 10;
  localparam int THR = 3000;
  localparam int LIM = 200;

  logic clk = 0, rst_n = 0;
  logic pulse_valid = 0;
  logic [15:0] pulse_len = '0;
  logic cal_allow = 0, rev_mode = 0;
  logic settle_ack = 0, beep_ack = 0, gap_ack = 0;
  logic settle_req, beep_req, gap_req, learning, done, skip;
  logic [15:0] hi_ep, lo_ep, mid_ep;

  int checks = 0, failures = 0, n_done = 0, n_skip = 0;

  rc_cal_learner i_rc_cal_learner (
    .clk(clk), .rst_n(rst_n), .pulse_valid(pulse_valid), .pulse_len(pulse_len),
    .cal_allow(cal_allow), .rev_mode(rev_mode),
    .settle_req(settle_req), .settle_ack(settle_ack),
    .beep_req(beep_req), .beep_ack(beep_ack),
    .gap_req(gap_req), .gap_ack(gap_ack),
    .learning(learning), .done(done), .skip(skip),
    .hi_ep(hi_ep), .lo_ep(lo_ep), .mid_ep(mid_ep));

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    if (done) n_done++;
    if (skip) n_skip++;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int ep_of(input logic [23:0] s);
    return int'(s[20:5]);
  endfunction

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_done = 0; n_skip = 0;
  endtask

  task automatic send(input int p);
    @(negedge clk);
    pulse_valid = 1; pulse_len = 16'(p);
    @(negedge clk);
    pulse_valid = 0;
  endtask

  function automatic bit req_of(input int w);
    return (w == 0) ? settle_req : (w == 1) ? beep_req : gap_req;
  endfunction

  task automatic handshake(input int w, output bit got);
    got = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (req_of(w)) begin got = 1; break; end
    end
    if (got) begin
      if (w == 0) settle_ack = 1; else if (w == 1) beep_ack = 1; else gap_ack = 1;
      @(negedge clk);
      settle_ack = 0; beep_ack = 0; gap_ack = 0;
    end
  endtask

  task automatic run_samples(input int ref_p, input int n, inout logic [23:0] sum);
    for (int i = 0; i < n; i++) begin
      int p;
      if (i == 0) p = ref_p + LIM;
      else if (i == 1) p = ref_p - LIM;
      else p = ref_p + int'($urandom_range(0, 2*LIM)) - LIM;
      sum = sum + 24'(p);
      send(p);
    end
  endtask

  task automatic expect_beeps(input int k);
    bit got;
    send(4000);
    @(negedge clk);
    check(beep_req == 1, "R10 beep still pending", beep_req, 1);
    for (int i = 0; i < k; i++) begin
      handshake(1, got);
      check(got, "R8 beep request", got, 1);
      if (i < k - 1) begin
        handshake(2, got);
        check(got, "R8 gap request", got, 1);
      end
    end
    @(negedge clk);
    check(gap_req == 0 && beep_req == 0, "R8 nothing after last beep", gap_req, 0);
  endtask

  initial begin
    logic [23:0] s;
    bit got;
    int hv, lv, mv;
    void'($urandom(1234));

    // R1 reset state
    do_reset();
    check(learning == 0 && done == 0 && skip == 0, "R1 status", learning, 0);
    check(settle_req == 0 && beep_req == 0 && gap_req == 0, "R1 requests", beep_req, 0);
    check(hi_ep == 0 && lo_ep == 0 && mid_ep == 0, "R1 endpoints", hi_ep, 0);

    // R2 below threshold
    cal_allow = 1;
    send(THR - 1);
    send(3500);
    repeat (2) @(negedge clk);
    check(n_skip == 1, "R2 skip below threshold", n_skip, 1);
    check(learning == 0, "R2 no learning after later pulse", learning, 0);

    // R2 calibration not allowed
    do_reset();
    cal_allow = 0;
    send(3500);
    repeat (2) @(negedge clk);
    check(n_skip == 1 && learning == 0, "R2 skip when disallowed", n_skip, 1);

    // Forward-only run with drift and ordering rejection
    do_reset();
    cal_allow = 1; rev_mode = 0;
    send(THR);
    check(learning == 1, "R2 entry at threshold", learning, 1);
    s = '0;
    run_samples(THR, 3, s);
    send(THR + LIM + 1);
    @(negedge clk);
    check(settle_req == 1, "R5 drift high side", settle_req, 1);
    send(THR + 700);
    check(settle_req == 1, "R10 settle held over pulse", settle_req, 1);
    handshake(0, got);
    check(got, "R5 settle handshake", got, 1);
    send(3600);
    s = '0;
    run_samples(3600, 30, s);
    @(negedge clk);
    check(beep_req == 0, "R3 no endpoint after 30", beep_req, 0);
    send(3610); s = s + 24'(3610);
    hv = ep_of(s);
    expect_beeps(1);
    check(int'(hi_ep) == hv, "R3 full endpoint value", hi_ep, hv);
    send(hv);
    s = '0;
    send(1700);
    run_samples(1700, 33, s);
    @(negedge clk);
    check(beep_req == 0 && settle_req == 0, "R4 R7 no endpoint after 33", beep_req, 0);
    send(1705); s = s + 24'(1705);
    lv = ep_of(s);
    expect_beeps(2);
    repeat (2) @(negedge clk);
    check(n_done == 1 && learning == 0, "R9 done after stop", n_done, 1);
    check(int'(lo_ep) == lv, "R4 stop endpoint value", lo_ep, lv);
    check(mid_ep == 0, "R9 no neutral without reverse", mid_ep, 0);
    send(3600); send(1500); send(2500);
    repeat (2) @(negedge clk);
    check(int'(hi_ep) == hv && int'(lo_ep) == lv && mid_ep == 0, "R11 endpoints hold", hi_ep, hv);
    check(n_done == 1 && beep_req == 0, "R11 no further activity", n_done, 1);

    // Reverse run with neutral
    do_reset();
    rev_mode = 1;
    send(3500);
    s = '0;
    run_samples(3500, 31, s);
    hv = ep_of(s);
    expect_beeps(1);
    send(1600);
    s = '0;
    run_samples(1600, 34, s);
    lv = ep_of(s);
    expect_beeps(2);
    check(int'(lo_ep) == lv, "R4 reverse stop value", lo_ep, lv);
    send(lv - 1);
    send(2500);
    s = '0;
    run_samples(2500, 5, s);
    send(2500 - LIM - 1);
    @(negedge clk);
    check(settle_req == 1, "R5 drift low side", settle_req, 1);
    handshake(0, got);
    send(2500);
    s = '0;
    run_samples(2500, 31, s);
    @(negedge clk);
    check(beep_req == 0, "R4 no neutral after 31", beep_req, 0);
    send(2490); s = s + 24'(2490);
    mv = ep_of(s);
    expect_beeps(3);
    repeat (2) @(negedge clk);
    check(int'(mid_ep) == mv, "R4 neutral value", mid_ep, mv);
    check(int'(hi_ep) == hv && n_done == 1, "R9 reverse done", n_done, 1);

    // R6 restart below threshold
    do_reset();
    rev_mode = 0;
    send(3400);
    send(3400 + LIM + 5);
    handshake(0, got);
    check(got, "R6 settle before restart", got, 1);
    send(THR - 10);
    repeat (2) @(negedge clk);
    check(n_skip == 1 && learning == 0, "R6 abort below threshold", n_skip, 1);
    check(hi_ep == 0, "R6 nothing stored", hi_ep, 0);

    finish_run();
  end
endmodule